// File: doc/BRIEF.md
# Flash Hardware Reset Sequencer

This block sits between the external active-low reset pin of a flash memory model and its command interface. It brings the pin into the clock domain and ignores pulses that are too short. When a pulse is long enough, it accepts the reset and sends a one-cycle abort strobe to the command decoder. If a program or erase is running at that moment, it also raises a corruption strobe so the target location can be marked invalid. It then holds the ready/busy output low until the internal reset has run its full duration.

Reads are blocked by a separate qualifier. This qualifier drops when the reset is accepted. It rises again only after a recovery delay, and that delay starts from whichever comes later: internal completion or release of the pin. All three durations are given in nanoseconds together with the clock period. They are turned into whole clock cycles at elaboration time.

Top module: `flash_rst_seq`

## Requirements
- R1: After system reset, `ready_o` and `rd_en_o` are 1, and `abort_o` and `corrupt_o` are 0.
- R2: The pin goes through a two-stage synchronizer. A low pulse seen for fewer than MIN_CYC consecutive synchronized samples has no effect: no abort, and `ready_o` and `rd_en_o` stay 1.
- R3: A low pulse seen for at least MIN_CYC samples is accepted. When the pin is first driven low before clock edge 1, `abort_o` is 1 for exactly one cycle, after edge MIN_CYC+2.
- R4: `corrupt_o` pulses together with `abort_o` only when `op_busy_i` is 1 at the acceptance edge. Otherwise it stays 0.
- R5: `ready_o` (1 = ready) goes low at acceptance and returns high after edge INT_CYC+2, counted from the first low sample. This holds whether the pin was released earlier or not.
- R6: `rd_en_o` goes low at acceptance. It returns high REC_CYC cycles after the later of two events: internal completion, or the first high synchronized sample after release (edge L+3 for a pulse driven low for L cycles).
- R7: A new low on the pin during the recovery window starts a fresh qualification while reads stay blocked. A short pulse there restarts the recovery from its own release. A long pulse there is accepted as a new reset.
- R8: Pin activity while the internal reset is running produces no second abort and does not move the completion point. If the pin is low at completion, the recovery waits for its release.
- R9: Each duration in cycles is the duration in ns divided by the clock period, rounded up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rst_pin_n | input | 1 | External flash reset pin, active low, asynchronous |
| op_busy_i | input | 1 | A program or erase is in progress |
| abort_o | output | 1 | One-cycle strobe: abort the current operation |
| corrupt_o | output | 1 | One-cycle strobe: the location being written is invalid |
| ready_o | output | 1 | Ready/busy: 1 ready, 0 busy in reset |
| rd_en_o | output | 1 | Reads permitted |

## Verification
The bench sweeps the pulse length across the whole range. This includes pulses one cycle short of acceptance and exactly at acceptance, releases before, at and after internal completion, and the case where the recovery should start from completion rather than release. An off-by-one in qualification would abort on a pulse that should be ignored. Restarting the count on release would make busy end too early. A design that took the earlier of the two events would let reads through before recovery. Extra scenarios retrigger the pin during recovery and during the internal reset. A sequencer that cleared the read lock on a short pulse, or aborted twice, shows a wrong strobe or an early read enable.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUAL,
    ST_ACTIVE,
    ST_HOLD,
    ST_RECOV
  } frs_state_e;

  // Round a duration up to whole clock cycles.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_n = d_i;
    end else begin : g_many
      always_comb sh_n = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_n;
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/frs_cnt.sv
module frs_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_n;
  logic         cnt_en;

  assign cnt_en = ld_i | inc_i;

  always_comb begin
    cnt_n = cnt_q;
    if (ld_i)       cnt_n = ld_val_i;
    else if (inc_i) cnt_n = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
  import flash_rst_pkg::*;
#(
  parameter int unsigned CLK_NS   = 8,
  parameter int unsigned MIN_NS   = 500,
  parameter int unsigned INT_NS   = 20000,
  parameter int unsigned REC_NS   = 1500,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin_n,
  input  logic op_busy_i,
  output logic abort_o,
  output logic corrupt_o,
  output logic ready_o,
  output logic rd_en_o
);

  localparam int unsigned RAW_MIN = ns_to_cyc(MIN_NS, CLK_NS);
  localparam int unsigned RAW_INT = ns_to_cyc(INT_NS, CLK_NS);
  localparam int unsigned RAW_REC = ns_to_cyc(REC_NS, CLK_NS);
  localparam int unsigned MIN_CYC = (RAW_MIN < 2) ? 2 : RAW_MIN;
  localparam int unsigned INT_CYC = (RAW_INT <= MIN_CYC) ? MIN_CYC + 1 : RAW_INT;
  localparam int unsigned REC_CYC = (RAW_REC < 1) ? 1 : RAW_REC;
  localparam int unsigned TOP_CYC = (INT_CYC > REC_CYC) ? INT_CYC : REC_CYC;
  localparam int unsigned CW      = $clog2(TOP_CYC + 1);

  localparam logic [CW-1:0] MIN_LAST = CW'(MIN_CYC - 1);
  localparam logic [CW-1:0] INT_LAST = CW'(INT_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic          pin_s;
  frs_state_e    st_q, st_n;
  logic          ld, inc;
  logic [CW-1:0] ld_val;
  logic [CW-1:0] cnt;
  logic          accept;
  logic          lock_clr;
  logic          abort_q, corrupt_q, lock_q;
  logic          lock_n;
  logic          lock_en;

  frs_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rst_pin_n),
    .q_o   (pin_s)
  );

  frs_cnt #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (ld),
    .ld_val_i (ld_val),
    .inc_i    (inc),
    .cnt_o    (cnt)
  );

  // Next-state logic
  always_comb begin
    st_n     = st_q;
    ld       = 1'b0;
    ld_val   = '0;
    inc      = 1'b0;
    accept   = 1'b0;
    lock_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!pin_s) begin
          st_n   = ST_QUAL;
          ld     = 1'b1;
          ld_val = ONE;
        end
      end
      ST_QUAL: begin
        if (pin_s) begin
          st_n = lock_q ? ST_RECOV : ST_IDLE;
          ld   = 1'b1;
        end else begin
          inc = 1'b1;
          if (cnt == MIN_LAST) begin
            st_n   = ST_ACTIVE;
            accept = 1'b1;
          end
        end
      end
      ST_ACTIVE: begin
        if (cnt == INT_LAST) begin
          st_n = pin_s ? ST_RECOV : ST_HOLD;
          ld   = 1'b1;
        end else begin
          inc = 1'b1;
        end
      end
      ST_HOLD: begin
        if (pin_s) begin
          st_n = ST_RECOV;
          ld   = 1'b1;
        end
      end
      ST_RECOV: begin
        if (!pin_s) begin
          st_n   = ST_QUAL;
          ld     = 1'b1;
          ld_val = ONE;
        end else if (cnt == REC_LAST) begin
          st_n     = ST_IDLE;
          lock_clr = 1'b1;
        end else begin
          inc = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign lock_en = accept | lock_clr;
  assign lock_n  = accept;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      abort_q   <= 1'b0;
      corrupt_q <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      st_q      <= st_n;
      abort_q   <= accept;
      corrupt_q <= accept & op_busy_i;
      if (lock_en) lock_q <= lock_n;
    end
  end

  assign abort_o   = abort_q;
  assign corrupt_o = corrupt_q;
  assign ready_o   = (st_q != ST_ACTIVE);
  assign rd_en_o   = ~lock_q;

  // Assertions
  assert_abort_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
  assert_abort_pin_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !$past(pin_s));
  assert_corrupt_with_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    corrupt_o |-> abort_o);
  assert_busy_on_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!ready_o && !rd_en_o));
  assert_ready_drop_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> abort_o);
  assert_lock_covers_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> !rd_en_o);
  assert_read_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en_o) |-> (ready_o && $past(ready_o)));

endmodule

// File: tb/flash_rst_seq_tb.sv
module flash_rst_seq_tb_top;

  localparam int unsigned CLK_NS = 8;
  localparam int unsigned MIN_NS = 40;
  localparam int unsigned INT_NS = 160;
  localparam int unsigned REC_NS = 50;
  // R9: rounding up to whole cycles (5, 20, 7)
  localparam int MIN = (MIN_NS + CLK_NS - 1) / CLK_NS;
  localparam int INT = (INT_NS + CLK_NS - 1) / CLK_NS;
  localparam int REC = (REC_NS + CLK_NS - 1) / CLK_NS;

  logic clk;
  logic rst_n;
  logic pin_n;
  logic busy;
  logic abort, corrupt, ready, rd_en;

  int n_run;
  int n_fail;

  flash_rst_seq #(
    .CLK_NS(CLK_NS), .MIN_NS(MIN_NS), .INT_NS(INT_NS), .REC_NS(REC_NS), .SYNC_STG(2)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_pin_n (pin_n),
    .op_busy_i (busy),
    .abort_o   (abort),
    .corrupt_o (corrupt),
    .ready_o   (ready),
    .rd_en_o   (rd_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what, input int sc, input int j,
                     input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s scenario %0d cycle %0d: actual %b expected %b",
               tag, what, sc, j, act, exp);
    end
  endtask

  function automatic bit inr(input int j, input int a, input int b);
    return (j >= a) && (j < b);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Pin low pattern per scenario
  function automatic bit low_at(input int sc, input int len, input int j);
    case (sc)
      0:       return j < len;
      1:       return (j < 8) || inr(j, 24, 26);
      2:       return (j < 8) || inr(j, 24, 34);
      3:       return (j < 6) || inr(j, 10, 12);
      default: return (j < 6) || inr(j, 10, 30);
    endcase
  endfunction

  task automatic run_scn(input int sc, input int len, input logic bz);
    bit   acc;
    logic e_ab, e_rdy, e_rd;
    string t_ab, t_rdy, t_rd;
    busy = bz;
    for (int j = 0; j <= 64; j++) begin
      if (j > 0) begin
        acc = (sc != 0) || (len >= MIN);
        t_ab = "R3"; t_rdy = "R5"; t_rd = "R6";
        case (sc)
          0: begin
            e_ab  = acc && (j == MIN + 2);
            e_rdy = !(acc && inr(j, MIN + 2, INT + 2));
            e_rd  = !(acc && inr(j, MIN + 2, imax(len + 3, INT + 2) + REC));
            if (!acc) begin t_ab = "R2"; t_rdy = "R2"; t_rd = "R2"; end
          end
          1: begin // R7 short pulse in recovery
            e_ab  = (j == MIN + 2);
            e_rdy = !inr(j, MIN + 2, INT + 2);
            e_rd  = !inr(j, MIN + 2, 26 + 3 + REC);
            t_ab = "R7"; t_rd = "R7";
          end
          2: begin // R7 long pulse in recovery
            e_ab  = (j == MIN + 2) || (j == 24 + MIN + 2);
            e_rdy = !(inr(j, MIN + 2, INT + 2) || inr(j, 24 + MIN + 2, 24 + INT + 2));
            e_rd  = !inr(j, MIN + 2, 24 + imax(13, INT + 2) + REC);
            t_ab = "R7"; t_rdy = "R7"; t_rd = "R7";
          end
          3: begin // R8 short re-low during internal reset
            e_ab  = (j == MIN + 2);
            e_rdy = !inr(j, MIN + 2, INT + 2);
            e_rd  = !inr(j, MIN + 2, INT + 2 + REC);
            t_ab = "R8"; t_rdy = "R8";
          end
          default: begin // R8 pin low again across completion
            e_ab  = (j == MIN + 2);
            e_rdy = !inr(j, MIN + 2, INT + 2);
            e_rd  = !inr(j, MIN + 2, 30 + 3 + REC);
            t_ab = "R8"; t_rd = "R8";
          end
        endcase
        chk(t_ab,  "abort_o",   sc, j, abort, e_ab);
        chk("R4",  "corrupt_o", sc, j, corrupt, e_ab & bz);
        chk(t_rdy, "ready_o",   sc, j, ready, e_rdy);
        chk(t_rd,  "rd_en_o",   sc, j, rd_en, e_rd);
      end
      pin_n = !low_at(sc, len, j);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    n_run  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    pin_n  = 1'b1;
    busy   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "abort_o",   -1, 0, abort, 1'b0);
    chk("R1", "corrupt_o", -1, 0, corrupt, 1'b0);
    chk("R1", "ready_o",   -1, 0, ready, 1'b1);
    chk("R1", "rd_en_o",   -1, 0, rd_en, 1'b1);
    // R2 R3 R5 R6: sweep of pulse length
    for (int len = 1; len <= INT + 6; len++) begin
      run_scn(0, len, len[0]);
    end
    run_scn(1, 0, 1'b1);
    run_scn(2, 0, 1'b0);
    run_scn(3, 0, 1'b1);
    run_scn(4, 0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule